// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

This block shifts or rotates a 32-bit operand by a variable amount for a processor datapath. It also produces the carry bit the shift would leave behind, plus a strobe that tells the flag logic whether to write that carry. Five shift kinds are supported: logical left, logical right, arithmetic right, rotate right, and a one-bit rotate right through the carry flag. The shift amount is an 8-bit unsigned value, so amounts from 0 to 255 are legal. The carry rules cover every region: zero, 1 to 31, exactly 32, and beyond 32.

Operands enter on a valid/ready stream, and results leave on another one after a single register stage. An operand is taken on a clock edge when `in_valid` and `in_ready` are both high. A result is handed over on an edge when `out_valid` and `out_ready` are both high. `in_ready` is high when the output register is empty or is being drained in the same cycle, so back-pressure on the output stalls the input at once. While a result waits, it is held unchanged.

When the carry strobe is low, `out_carry` repeats the incoming carry flag. A consumer can therefore write `out_carry` to the flag without any extra selection.

Top module: `shift_carry_unit`

## Requirements
- R1: For kind codes 0 to 3 with an amount of 0, the result equals the operand, `out_cvalid` is 0 and `out_carry` equals `in_carry`.
- R2: Kind 0 (logical left), amount n from 1 to 31: the result is the operand shifted left with zeros filled in below, and the carry is operand bit 32-n. For n = 32 the result is 0 and the carry is bit 0. For n of 33 or more the result and the carry are 0. `out_cvalid` is 1 for every nonzero n.
- R3: Kind 1 (logical right), amount n from 1 to 31: zeros fill the top bits and the carry is operand bit n-1. For n = 32 the result is 0 and the carry is bit 31. For n of 33 or more the result and the carry are 0. `out_cvalid` is 1.
- R4: Kind 2 (arithmetic right), amount n from 1 to 31: copies of operand bit 31 fill the top n bits and the carry is bit n-1. For n of 32 or more, every result bit and the carry equal bit 31. `out_cvalid` is 1.
- R5: Kind 3 (rotate right), nonzero amount n: the result is the operand rotated right by n mod 32, and the carry is operand bit (n-1) mod 32. So n = 32, 64 and so on return the operand with carry = bit 31. `out_cvalid` is 1.
- R6: Kind 4 (rotate through carry) ignores the amount. The result is {in_carry, operand[31:1]}, the carry is operand bit 0, and `out_cvalid` is 1.
- R7: Kind codes 5, 6 and 7 pass the operand through, with `out_cvalid` 0 and `out_carry` equal to `in_carry`.
- R8: `in_ready` equals (not `out_valid`) or `out_ready`. An operand accepted on one edge appears on the output from the next edge. While `out_valid` is high and `out_ready` is low, all output fields stay stable.
- R9: While `rst_n` is low, and after reset until the first operand is accepted, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Operand can be taken this cycle |
| in_data | input | 32 | Operand to shift |
| in_amt | input | 8 | Shift amount, unsigned |
| in_kind | input | 3 | Shift kind code (see R2 to R7) |
| in_carry | input | 1 | Current carry flag |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 32 | Shifted result |
| out_carry | output | 1 | Carry to write, or the incoming carry when not written |
| out_cvalid | output | 1 | Carry flag should be written |

## Verification
The bench builds the block with its default parameters, a 32-bit operand and an 8-bit amount. With an 8-bit amount the stimulus can reach every carry region: 0, 1 to 31, exactly 32, 33, and rotations that wrap several times (64, 65, 255). Directed sweeps cross all eight kind codes with these boundary amounts, on sign-heavy, alternating and all-ones operands. Random traffic follows, with random idle cycles and random holds on `out_ready`, so the stall-hold and ready rules are exercised together with the data rules.

// File: rtl/shift_carry_pkg.sv
package shift_carry_pkg;
  typedef enum logic [2:0] {
    SK_LSL = 3'd0,
    SK_LSR = 3'd1,
    SK_ASR = 3'd2,
    SK_ROR = 3'd3,
    SK_RRX = 3'd4
  } shift_kind_e;
endpackage

// File: rtl/sc_right_barrel.sv
// Logarithmic right shifter: one stage per amount bit, each stage either
// rotates or shifts in a fill bit.
module sc_right_barrel #(
  parameter int WIDTH = 32,
  parameter int LOG_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] vec_i,
  input  logic [LOG_W-1:0] amt_i,
  input  logic             fill_i,
  input  logic             rotate_i,
  output logic [WIDTH-1:0] vec_o
);
  logic [LOG_W:0][WIDTH-1:0] stage_v;

  assign stage_v[0] = vec_i;

  for (genvar s = 0; s < LOG_W; s++) begin : g_stage
    localparam int STEP = 1 << s;
    logic [WIDTH-1:0] moved;
    assign moved = rotate_i ? {stage_v[s][STEP-1:0], stage_v[s][WIDTH-1:STEP]}
                            : {{STEP{fill_i}}, stage_v[s][WIDTH-1:STEP]};
    assign stage_v[s+1] = amt_i[s] ? moved : stage_v[s];
  end

  assign vec_o = stage_v[LOG_W];
endmodule

// File: rtl/sc_shift_datapath.sv
// Combinational result and carry selection for all shift kinds.
module sc_shift_datapath
  import shift_carry_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8
) (
  input  logic [WIDTH-1:0] op_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic [2:0]       kind_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] res_o,
  output logic             carry_o,
  output logic             cvalid_o
);
  localparam int LOG_W = $clog2(WIDTH);
  localparam logic [AMT_W-1:0] W_AMT = AMT_W'(WIDTH);

  function automatic logic [WIDTH-1:0] flip(input logic [WIDTH-1:0] v);
    logic [WIDTH-1:0] f;
    for (int i = 0; i < WIDTH; i++) f[i] = v[WIDTH-1-i];
    return f;
  endfunction

  logic             is_lsl, is_asr, is_ror;
  logic             amt_zero, amt_ge_w, amt_gt_w, msb;
  logic [AMT_W-1:0] amt_m1, amt_neg;
  logic [LOG_W-1:0] idx_dn, idx_up;
  logic [WIDTH-1:0] barrel_in, barrel_out;
  logic [WIDTH-1:0] res_sel;
  logic             carry_sel, cv_sel;

  assign is_lsl   = (kind_i == SK_LSL);
  assign is_asr   = (kind_i == SK_ASR);
  assign is_ror   = (kind_i == SK_ROR);
  assign msb      = op_i[WIDTH-1];
  assign amt_zero = (amt_i == '0);
  assign amt_ge_w = (amt_i >= W_AMT);
  assign amt_gt_w = (amt_i > W_AMT);
  assign amt_m1   = amt_i - 1'b1;
  assign amt_neg  = ~amt_i + 1'b1;
  // (n-1) mod W and (W-n) mod W, W being a power of two
  assign idx_dn   = amt_m1[LOG_W-1:0];
  assign idx_up   = amt_neg[LOG_W-1:0];

  // Left shifts run through the right shifter on a bit-reversed operand
  assign barrel_in = is_lsl ? flip(op_i) : op_i;

  sc_right_barrel #(.WIDTH(WIDTH), .LOG_W(LOG_W)) u_barrel (
    .vec_i    (barrel_in),
    .amt_i    (amt_i[LOG_W-1:0]),
    .fill_i   (is_asr & msb),
    .rotate_i (is_ror),
    .vec_o    (barrel_out)
  );

  always_comb begin
    res_sel   = op_i;
    carry_sel = carry_i;
    cv_sel    = 1'b0;
    unique case (kind_i)
      SK_LSL: begin
        res_sel   = amt_ge_w ? '0 : flip(barrel_out);
        carry_sel = amt_gt_w ? 1'b0 : op_i[idx_up];
        cv_sel    = ~amt_zero;
      end
      SK_LSR: begin
        res_sel   = amt_ge_w ? '0 : barrel_out;
        carry_sel = amt_gt_w ? 1'b0 : op_i[idx_dn];
        cv_sel    = ~amt_zero;
      end
      SK_ASR: begin
        res_sel   = amt_ge_w ? {WIDTH{msb}} : barrel_out;
        carry_sel = amt_ge_w ? msb : op_i[idx_dn];
        cv_sel    = ~amt_zero;
      end
      SK_ROR: begin
        res_sel   = barrel_out;
        carry_sel = op_i[idx_dn];
        cv_sel    = ~amt_zero;
      end
      SK_RRX: begin
        res_sel   = {carry_i, op_i[WIDTH-1:1]};
        carry_sel = op_i[0];
        cv_sel    = 1'b1;
      end
      default: begin
        res_sel   = op_i;
        carry_sel = carry_i;
        cv_sel    = 1'b0;
      end
    endcase
  end

  assign res_o    = res_sel;
  assign cvalid_o = cv_sel;
  assign carry_o  = cv_sel ? carry_sel : carry_i;
endmodule

// File: rtl/sc_out_stage.sv
// Single register stage with valid/ready on both sides.
module sc_out_stage #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_res,
  input  logic             in_carry,
  input  logic             in_cvalid,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_res,
  output logic             out_carry,
  output logic             out_cvalid
);
  logic take;

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_res    <= '0;
      out_carry  <= 1'b0;
      out_cvalid <= 1'b0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (take) begin
        out_res    <= in_res;
        out_carry  <= in_carry;
        out_cvalid <= in_cvalid;
      end
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_res)
                                   && $stable(out_carry) && $stable(out_cvalid))) // R8
    else $error("stalled output changed");

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid) // R8
    else $error("accepted operand not presented");
endmodule

// File: rtl/shift_carry_unit.sv
module shift_carry_unit
  import shift_carry_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  input  logic [AMT_W-1:0] in_amt,
  input  logic [2:0]       in_kind,
  input  logic             in_carry,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data,
  output logic             out_carry,
  output logic             out_cvalid
);
  localparam logic [AMT_W-1:0] W_AMT = AMT_W'(WIDTH);

  logic [WIDTH-1:0] comb_res;
  logic             comb_carry, comb_cv;

  sc_shift_datapath #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_dp (
    .op_i     (in_data),
    .amt_i    (in_amt),
    .kind_i   (in_kind),
    .carry_i  (in_carry),
    .res_o    (comb_res),
    .carry_o  (comb_carry),
    .cvalid_o (comb_cv)
  );

  sc_out_stage #(.WIDTH(WIDTH)) u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_res     (comb_res),
    .in_carry   (comb_carry),
    .in_cvalid  (comb_cv),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_res    (out_data),
    .out_carry  (out_carry),
    .out_cvalid (out_cvalid)
  );

  logic fire;
  assign fire = in_valid & in_ready;

  AST_ZERO_AMT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_kind < 3'd4 && in_amt == '0) |=>
      (out_data == $past(in_data) && !out_cvalid && out_carry == $past(in_carry))) // R1
    else $error("zero amount altered operand or carry");

  AST_LSL_FAR: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_kind == SK_LSL && in_amt > W_AMT) |=>
      (out_data == '0 && out_cvalid && !out_carry)) // R2
    else $error("far left shift wrong");

  AST_LSR_FAR: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_kind == SK_LSR && in_amt > W_AMT) |=>
      (out_data == '0 && out_cvalid && !out_carry)) // R3
    else $error("far logical right shift wrong");

  AST_ASR_FAR: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_kind == SK_ASR && in_amt >= W_AMT) |=>
      (out_data == {WIDTH{$past(in_data[WIDTH-1])}}
       && out_carry == $past(in_data[WIDTH-1]) && out_cvalid)) // R4
    else $error("far arithmetic shift wrong");

  AST_ROR_FULL_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_kind == SK_ROR && in_amt == W_AMT) |=>
      (out_data == $past(in_data) && out_carry == $past(in_data[WIDTH-1]) && out_cvalid)) // R5
    else $error("full-turn rotate wrong");

  AST_RRX_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_kind == SK_RRX) |=>
      (out_data == {$past(in_carry), $past(in_data[WIDTH-1:1])}
       && out_carry == $past(in_data[0]) && out_cvalid)) // R6
    else $error("rotate through carry wrong");

  AST_UNDEF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_kind > 3'd4) |=>
      (out_data == $past(in_data) && !out_cvalid && out_carry == $past(in_carry))) // R7
    else $error("undefined kind not passed through");
endmodule

// File: tb/shift_carry_unit_tb_top.sv
`timescale 1ns/1ps
module shift_carry_unit_tb_top;
  localparam int W  = 32;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0, in_ready;
  logic [W-1:0]  in_data = '0;
  logic [AW-1:0] in_amt = '0;
  logic [2:0]    in_kind = '0;
  logic          in_carry = 1'b0;
  logic          out_valid, out_ready = 1'b0;
  logic [W-1:0]  out_data;
  logic          out_carry, out_cvalid;

  always #2.5 clk = ~clk;

  shift_carry_unit #(.WIDTH(W), .AMT_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_amt(in_amt), .in_kind(in_kind), .in_carry(in_carry),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_carry(out_carry), .out_cvalid(out_cvalid)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  logic [W-1:0] q_d[$];
  logic         q_c[$];
  logic         q_v[$];
  string        q_t[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference built from the requirement text
  task automatic model(input logic [W-1:0] d, input int n, input int k, input logic c,
                       output logic [W-1:0] r, output logic co, output logic cv,
                       output string tag);
    r = d; co = c; cv = 1'b0; tag = "R7";
    if (k < 4 && n == 0) begin
      tag = "R1";
    end else begin
      case (k)
        0: begin
          tag = "R2"; cv = 1'b1;
          r  = (n >= 32) ? '0 : (d << n);
          co = (n > 32) ? 1'b0 : d[32-n];
        end
        1: begin
          tag = "R3"; cv = 1'b1;
          r  = (n >= 32) ? '0 : (d >> n);
          co = (n > 32) ? 1'b0 : d[n-1];
        end
        2: begin
          tag = "R4"; cv = 1'b1;
          r  = (n >= 32) ? {32{d[31]}} : 32'($signed(d) >>> n);
          co = (n >= 32) ? d[31] : d[n-1];
        end
        3: begin
          int m;
          tag = "R5"; cv = 1'b1;
          m  = n % 32;
          r  = (m == 0) ? d : ((d >> m) | (d << (32 - m)));
          co = d[(n-1) % 32];
        end
        4: begin
          tag = "R6"; cv = 1'b1;
          r  = {c, d[31:1]};
          co = d[0];
        end
        default: ;
      endcase
    end
  endtask

  // Monitor: compares on every clock, sampled after inputs settle
  always begin
    @(negedge clk);
    #1;
    if (!rst_n) begin
      chk(out_valid == 1'b0, "R9", "out_valid during reset", 64'(out_valid), 64'd0);
    end else begin
      chk(in_ready == (!out_valid || out_ready), "R8", "in_ready rule",
          64'(in_ready), 64'(!out_valid || out_ready));
      if (out_valid) begin
        if (q_d.size() == 0) begin
          chk(1'b0, "R9", "output with nothing accepted", 64'(out_data), 64'd0);
        end else begin
          chk(out_data == q_d[0] && out_carry == q_c[0] && out_cvalid == q_v[0], q_t[0],
              "result {cv,c,data}", {30'd0, out_cvalid, out_carry, out_data},
              {30'd0, q_v[0], q_c[0], q_d[0]});
          if (out_ready) begin
            void'(q_d.pop_front()); void'(q_c.pop_front());
            void'(q_v.pop_front()); void'(q_t.pop_front());
          end
        end
      end
      if (in_valid && in_ready) begin
        logic [W-1:0] r; logic co, cv; string tg;
        model(in_data, int'(in_amt), int'(in_kind), in_carry, r, co, cv, tg);
        q_d.push_back(r); q_c.push_back(co); q_v.push_back(cv); q_t.push_back(tg);
      end
    end
  end

  task automatic send(input logic [W-1:0] d, input logic [AW-1:0] n,
                      input logic [2:0] k, input logic c);
    bit acc;
    @(negedge clk);
    #0.5;
    in_valid = 1'b1; in_data = d; in_amt = n; in_kind = k; in_carry = c;
    out_ready = ($urandom_range(0, 3) != 0);
    #0.5;
    acc = in_ready;
    while (!acc) begin
      @(negedge clk);
      #0.5;
      out_ready = ($urandom_range(0, 3) != 0);
      #0.5;
      acc = in_ready;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    #0.5;
    in_valid = 1'b0;
    out_ready = ($urandom_range(0, 1) != 0);
  endtask

  logic [W-1:0] pats[4] = '{32'h8000_0001, 32'h7fff_ffff, 32'ha5a5_c3c3, 32'hffff_ffff};
  int           amts[11] = '{0, 1, 2, 16, 31, 32, 33, 63, 64, 65, 255};

  initial begin
    repeat (4) @(negedge clk);
    #0.5 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // Directed boundary sweep over every kind code (R1..R7)
    for (int k = 0; k < 8; k++)
      for (int a = 0; a < 11; a++)
        for (int p = 0; p < 4; p++)
          for (int c = 0; c < 2; c++)
            send(pats[p], AW'(amts[a]), 3'(k), 1'(c));
    // Random traffic with idle cycles and back-pressure (R8)
    for (int i = 0; i < 1500; i++) begin
      if ($urandom_range(0, 5) == 0) idle();
      send($urandom(), AW'($urandom_range(0, 255)), 3'($urandom_range(0, 7)),
           1'($urandom_range(0, 1)));
    end
    @(negedge clk);
    #0.5;
    in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(q_d.size() == 0, "R8", "results left undelivered", 64'(q_d.size()), 64'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R8 watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule